// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked master and a 512K x 16 asynchronous static RAM. The memory has active-low chip select, write strobe, read strobe and two byte selects. The master issues single-word requests over a valid/ready handshake. Each request carries a 19-bit word address, a write flag, 16 bits of write data and a 2-bit lane mask. A read returns its 16-bit word with a one-cycle valid pulse. The controller turns each request into a sequence of four phases (idle, setup, access, recover). Each phase lasts a whole number of clock cycles, computed from nanosecond timing parameters and the clock period.

Writes are controlled by the write strobe, and only the masked lanes are written. The read strobe stays high for the whole write. The controller's data drivers stay on until one cycle after the write strobe has risen. After a read, the controller keeps the read strobe high for the memory's release time before the next access may begin. The memory and the controller therefore never drive the data wires at the same time. Between requests the chip select is held high, so the memory stays in standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the transaction has finished.
- R2: While idle, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are all high, and `mem_dq_oe` is low. After reset the controller is idle.
- R3: In a read, chip select and the read strobe are low and the write strobe is high. The word is sampled ceil(T_AA_NS/CLK_NS) cycles after the accepting edge, and `rd_valid` is high for exactly one cycle at that point. Mask bit 0 selects bits 7:0 (`mem_lb_n` low) and mask bit 1 selects bits 15:8 (`mem_ub_n` low). A lane whose mask bit is 0 returns zero in `rd_data`.
- R4: In a write, the read strobe is high and the write strobe is low for max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)) cycles. Only the lanes whose mask bit is 1 are changed in memory. A mask of 00 changes nothing.
- R5: The memory address changes only on an edge where the write strobe is high both before and after that edge.
- R6: The controller drives the data wires only while the read strobe is high. Its write data is stable and driven at the edge where the write strobe rises.
- R7: After a read, the read strobe stays high for ceil(T_HZ_NS/CLK_NS) cycles before `req_ready` returns. The controller never enables its drivers while the memory may still be driving.
- R8: A write returns to idle max(ceil(T_WC_NS/CLK_NS), write-strobe cycles + 2) cycles after the accepting edge. A read returns to idle ceil(T_AA_NS/CLK_NS) + ceil(T_HZ_NS/CLK_NS) cycles after it.
- R9: Every phase length is the ceiling of its timing divided by the clock period, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_data | output | 16 | Read word, unselected lanes zero |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The assertions check the following on every cycle:
- the standby state of all pins while idle;
- that the address moves only with the write strobe high;
- that the drivers are off whenever the read strobe is low;
- that write data is held across the rising write strobe;
- the minimum write-strobe width and the release wait before drivers turn on;
- the single-cycle read pulse.

Only the bench scenarios can show that data reaches the right lanes, that a masked read returns zeros, and that the sampling point falls after the memory's access time. They run against a memory model that returns garbage until the access time has passed and flags overlapping drivers. The exact phase-length totals for reads and writes are also checked only there.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACCESS  = 2'd2,
    ST_RECOVER = 2'd3
  } phase_e;

  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  // Whole cycles covering a nanosecond interval, at least one.
  function automatic int ns_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= len - CW'(1);
    end else if (count != '0) begin
      count <= count - CW'(1);
    end
  end

  assign last = (count == '0);
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_lane_pkg::*;
#(
  parameter int CW     = 4,
  parameter int RD_ACC = 6,
  parameter int WR_ACC = 4,
  parameter int RD_REC = 4,
  parameter int WR_REC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic          last,
  output phase_e        phase,
  output logic          load,
  output logic [CW-1:0] len
);
  phase_e nxt;

  always_comb begin
    nxt  = phase;
    load = 1'b0;
    len  = CW'(1);
    unique case (phase)
      ST_IDLE: if (start) begin
        nxt  = ST_SETUP;
        load = 1'b1;
        len  = CW'(1);
      end
      ST_SETUP: if (last) begin
        nxt  = ST_ACCESS;
        load = 1'b1;
        len  = is_wr ? CW'(WR_ACC) : CW'(RD_ACC);
      end
      ST_ACCESS: if (last) begin
        nxt  = ST_RECOVER;
        load = 1'b1;
        len  = is_wr ? CW'(WR_REC) : CW'(RD_REC);
      end
      ST_RECOVER: if (last) begin
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= ST_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lane_en,
  input  logic          active,
  input  logic          capture,
  input  logic [LW-1:0] din,
  output logic          lane_n,
  output logic [LW-1:0] rdq
);
  assign lane_n = !(active && lane_en);

  always_ff @(posedge clk) begin
    if (!rst_n)       rdq <= '0;
    else if (capture) rdq <= lane_en ? din : '0;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW      = 19,
  parameter int CLK_NS  = 8,
  parameter int T_AA_NS = 55,
  parameter int T_WP_NS = 30,
  parameter int T_DW_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_HZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int AA_C   = ns_cycles(T_AA_NS, CLK_NS);
  localparam int WP_C   = ns_cycles(T_WP_NS, CLK_NS);
  localparam int DW_C   = ns_cycles(T_DW_NS, CLK_NS);
  localparam int WC_C   = ns_cycles(T_WC_NS, CLK_NS);
  localparam int HZ_C   = ns_cycles(T_HZ_NS, CLK_NS);
  localparam int RD_ACC = imax(1, AA_C - 1);
  localparam int WR_ACC = imax(WP_C, DW_C);
  localparam int WR_REC = imax(1, WC_C - 1 - WR_ACC);
  localparam int RD_REC = HZ_C;
  localparam int MAXLEN = imax(imax(RD_ACC, WR_ACC), imax(RD_REC, WR_REC));
  localparam int CW     = $clog2(MAXLEN + 1);

  phase_e             phase;
  logic               load;
  logic [CW-1:0]      len;
  logic               last;
  logic               accept;
  logic               capture;
  logic               active;
  logic               wr_q;
  logic [AW-1:0]      addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   mask_q;
  logic [LANES-1:0]   lane_n;
  logic               rd_valid_q;

  // named events
  assign req_ready = (phase == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign active    = (phase != ST_IDLE);
  assign capture   = (phase == ST_ACCESS) && last && !wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= capture;
  end

  sram_phase_seq #(
    .CW(CW), .RD_ACC(RD_ACC), .WR_ACC(WR_ACC), .RD_REC(RD_REC), .WR_REC(WR_REC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .is_wr(wr_q), .last(last),
    .phase(phase), .load(load), .len(len)
  );

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .len(len), .last(last)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_byte_lane #(.LW(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .lane_en(mask_q[i]), .active(active),
      .capture(capture), .din(mem_dq_in[i*LANE_W +: LANE_W]),
      .lane_n(lane_n[i]), .rdq(rd_data[i*LANE_W +: LANE_W])
    );
  end

  assign rd_valid   = rd_valid_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !active;
  assign mem_we_n   = !(wr_q && phase == ST_ACCESS);
  assign mem_oe_n   = !(!wr_q && (phase == ST_SETUP || phase == ST_ACCESS));
  assign mem_lb_n   = lane_n[0];
  assign mem_ub_n   = lane_n[LANES-1];
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = wr_q && active;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW    = 19,
  parameter int WP_CY = 4,
  parameter int HZ_CY = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic          mem_dq_oe,
  input logic [15:0]   mem_dq_out
);
  int unsigned we_low_cnt;
  int unsigned oe_quiet_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_cnt   <= 0;
      oe_quiet_cnt <= HZ_CY;
    end else begin
      we_low_cnt   <= mem_we_n ? 0 : we_low_cnt + 1;
      if (!mem_oe_n)             oe_quiet_cnt <= 0;
      else if (oe_quiet_cnt < HZ_CY) oe_quiet_cnt <= oe_quiet_cnt + 1;
    end
  end

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r2_standby_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

  a_r3_read_strobe_context: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  a_r3_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r4_write_strobe_context: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  a_r4_write_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= WP_CY));

  a_r5_addr_moves_with_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

  a_r6_no_drive_with_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r6_hold_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

  a_r7_release_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_quiet_cnt >= HZ_CY));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .AW(AW),
  .WP_CY(sram_lane_pkg::ns_cycles(T_WP_NS, CLK_NS)),
  .HZ_CY(sram_lane_pkg::ns_cycles(T_HZ_NS, CLK_NS))
) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
  .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
  localparam int CLK  = 8;
  localparam int T_AA = 55, T_WP = 30, T_DW = 25, T_WC = 55, T_HZ = 25;

  // bench's own cycle count: smallest n with n*CLK >= ns, at least one
  function automatic int cyc(input int ns);
    int n = 0;
    while (n * CLK < ns) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  function automatic int wr_total();
    int strobe = (cyc(T_WP) > cyc(T_DW)) ? cyc(T_WP) : cyc(T_DW);
    return (cyc(T_WC) > strobe + 2) ? cyc(T_WC) : strobe + 2;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] masked(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rd_data, mem_dq_out, mdrv;
  logic [18:0] mem_addr;

  always #(CLK/2) clk = ~clk;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mdrv)
  );
  assign mdrv = model_q;

  // ---------------- memory model (samples between edges) ----------------
  logic [15:0] model_q = 16'h5A5A;
  logic [15:0] marr [int];
  logic [18:0] p_addr = '0;
  logic [15:0] p_dq = '0;
  logic p_we = 1, p_ce = 1, seen_fall = 0;
  int age = 0, we_low = 0, dq_stable = 0, tail = 0, since_fall = 0;
  int viol = 0, contend = 0;

  always @(negedge clk) begin
    logic drv_now;
    logic [15:0] w;
    if (rst_n) begin
      if (mem_addr != p_addr) begin
        if (!mem_we_n || !p_we) viol++;
        age = 1;
      end else if (age < 1000) age++;
      if (p_ce && !mem_ce_n) begin
        if (seen_fall && since_fall < cyc(T_WC)) viol++;
        seen_fall = 1; since_fall = 0;
      end
      since_fall++;
      if (mem_dq_oe && mem_dq_out == p_dq) dq_stable++;
      else dq_stable = mem_dq_oe ? 1 : 0;
      if (!p_we && mem_we_n && !mem_ce_n) begin
        if (we_low < cyc(T_WP) || dq_stable < cyc(T_DW) || !mem_dq_oe) viol++;
        w = marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 16'h0000;
        if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
        if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
        marr[int'(mem_addr)] = w;
      end
      we_low = mem_we_n ? 0 : we_low + 1;
      drv_now = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && (drv_now || tail > 0)) contend++;
      if (drv_now) tail = cyc(T_HZ);
      else if (tail > 0) tail--;
      if (drv_now && age >= cyc(T_AA)) begin
        w = marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 16'h0000;
        model_q <= {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'hA5 : w[7:0]};
      end else begin
        model_q <= 16'h5A5A;
      end
      p_addr = mem_addr; p_we = mem_we_n; p_ce = mem_ce_n; p_dq = mem_dq_out;
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  logic [15:0] shadow [int];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] m, input string tag);
    int n = 0, rdv_at = -1, pulses = 0;
    logic [15:0] got = '0, exp_w;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (n < 1000) begin
      if (rd_valid) begin
        pulses++;
        if (rdv_at < 0) begin rdv_at = n; got = rd_data; end
      end
      if (req_ready) break;
      n++;
      @(negedge clk);
    end
    exp_w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (wr) begin
      shadow[int'(a)] = merge(exp_w, d, m);
      check(n == wr_total(), {"R8 write idle latency ", tag}, n, wr_total());
      check(pulses == 0, {"R1 no read pulse on write ", tag}, pulses, 0);
    end else begin
      check(got == masked(exp_w, m), {"R3 R4 read data ", tag}, got, masked(exp_w, m));
      check(rdv_at == cyc(T_AA), {"R3 R9 read sample cycle ", tag}, rdv_at, cyc(T_AA));
      check(pulses == 1, {"R3 single valid pulse ", tag}, pulses, 1);
      check(n == cyc(T_AA) + cyc(T_HZ), {"R7 R8 read idle latency ", tag}, n,
            cyc(T_AA) + cyc(T_HZ));
    end
  endtask

  initial begin
    #(200000 * CLK);
    errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'h5EED);
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R2: idle pins after reset
    check(req_ready == 1, "R2 ready after reset", req_ready, 1);
    check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111,
          "R2 strobes high when idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1F);
    check(mem_dq_oe == 0, "R2 drivers off when idle", mem_dq_oe, 0);

    // directed corner cases
    do_op(1, 19'h00000, 16'h1234, 2'b11, "full write");
    do_op(0, 19'h00000, 16'h0000, 2'b11, "full read");
    do_op(1, 19'h00000, 16'hAB99, 2'b10, "upper-only write");
    do_op(0, 19'h00000, 16'h0000, 2'b11, "after upper write");
    do_op(1, 19'h00000, 16'h77CD, 2'b01, "lower-only write");
    do_op(0, 19'h00000, 16'h0000, 2'b01, "lower-only read");
    do_op(0, 19'h00000, 16'h0000, 2'b10, "upper-only read");
    do_op(1, 19'h00000, 16'hFFFF, 2'b00, "empty-mask write");
    do_op(0, 19'h00000, 16'h0000, 2'b11, "after empty-mask write");
    do_op(0, 19'h00000, 16'h0000, 2'b00, "empty-mask read");
    do_op(1, 19'h7FFFF, 16'hC3C3, 2'b11, "top address write");
    do_op(0, 19'h7FFFF, 16'h0000, 2'b11, "top address read");
    do_op(1, 19'h00001, 16'h0F0F, 2'b11, "write then read turnaround");
    do_op(0, 19'h00001, 16'h0000, 2'b11, "read after write");
    do_op(1, 19'h00002, 16'hBEEF, 2'b11, "write straight after read");

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [18:0] a;
      a = {(($urandom % 4) == 0) ? 13'($urandom) : 13'h0, 6'($urandom)};
      do_op(1'($urandom), a, 16'($urandom), 2'($urandom), "random");
    end

    check(contend == 0, "R6 R7 no bus overlap", contend, 0);
    check(viol == 0, "R4 R5 R8 memory timing rules", viol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule